// File: doc/BRIEF.md
# Floating-Point Register Move Unit

This block executes the register-to-register floating move of a RISC core and three variants of it that touch only the sign bit. The variants are absolute value, negate and negative absolute value. It owns a 32-entry register file of 64-bit floating values. It accepts one 32-bit instruction word per cycle together with a valid strobe. It reads the source register named by the instruction and writes the destination register at the next clock edge. Every operation is a bit-exact copy: no rounding takes place, no NaN is quieted and no status is produced.

The instruction word carries a record bit. When that bit is set, the unit also refreshes condition-register field 1 with the four summary bits of the floating status/control word, which is supplied on an input. The unit does not compare the result with zero. A word that does not decode to one of the four operations raises an illegal-instruction flag and leaves all state alone. A test port loads and reads the register file directly, so the register file can be preset and inspected.

Top module: `fpmv_unit`

## Requirements
- R1: Instruction bits are numbered 0 (MSB, `insn_word[31]`) to 31 (LSB). The fields are: primary opcode at bits 0–5, destination FRT at 6–10, source FRA at 11–15, source FRB at 16–20, extended opcode at 21–30 and the record bit at 31. The plain move is recognised when the primary opcode is 63 and the extended opcode is 72, which gives the base word 0xFC000090. The FRA field has no effect on the result.
- R2: The plain move writes the full 64-bit pattern of FRB into FRT unchanged. This holds for every value, including both signed zeros, both infinities, signalling NaNs and quiet NaNs (payload and quiet bit kept).
- R3: Extended opcode 264 (absolute value) writes FRB with bit 0 of the value (`[63]`, the sign) cleared. All other bits are kept.
- R4: Extended opcode 40 (negate) writes FRB with the sign bit inverted. All other bits are kept.
- R5: Extended opcode 136 (negative absolute value) writes FRB with the sign bit set. All other bits are kept.
- R6: With the record bit at 1, condition-register field 1 (`cr_q[27:24]`, CR bits 4–7) takes status bits 0–3 (`fpscr_in[31:28]`) in order at the write edge. All other condition-register bits stay the same.
- R7: With the record bit at 0, the condition register does not change. The status input never affects the value written to the register file.
- R8: While `insn_valid` is low, no register write and no condition-register update take place, and `fpr_we`, `cr_we` and `illegal` are low.
- R9: A valid word whose primary or extended opcode matches none of the four operations drives `illegal` high in the same cycle. It changes neither the register file nor the condition register.
- R10: When FRT equals FRB, the register ends up holding its own previous value with the operation's sign rule applied.
- R11: After reset, every register file entry and the condition register are zero.
- R12: The write result (`fpr_we`, `fpr_waddr`, `fpr_wdata`) is presented in the same cycle as the valid word and is stored at the next rising clock edge. A test-port write stores at the next rising edge, and the test-port read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word, bit 0 of the word at `[31]` |
| fpscr_in | input | 32 | Current floating status/control word |
| tp_we | input | 1 | Test-port write enable |
| tp_addr | input | 5 | Test-port register index |
| tp_wdata | input | 64 | Test-port write data |
| tp_rdata | output | 64 | Test-port read data (combinational) |
| fpr_we | output | 1 | Register file write this cycle |
| fpr_waddr | output | 5 | Destination register index |
| fpr_wdata | output | 64 | Value being written |
| cr_we | output | 1 | Condition-register field 1 update this cycle |
| cr_q | output | 32 | Condition register |
| illegal | output | 1 | Valid word is not a recognised move |

## Verification
The checker assumes the bench never issues a test-port write to the same register in a cycle when a valid instruction also writes it. It also assumes that `fpscr_in` and the instruction inputs change only between clock edges. The bench keeps to these assumptions in two ways. It changes all inputs on the falling edge only. It also loads the register file strictly before it issues any instruction. The bench sweeps all 1024 extended opcodes and all 64 primary opcodes, and each legal operation is run over a set of special floating patterns. It checks every result against a reference model that is built from the requirements.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;

   localparam int unsigned INSN_W  = 32;
   localparam int unsigned IDX_W   = 5;
   localparam int unsigned XO_W    = 10;
   localparam int unsigned PRIM_W  = 6;

   localparam logic [PRIM_W-1:0] PRIM_FLOAT = 6'd63;
   localparam logic [XO_W-1:0]   XO_COPY    = 10'd72;
   localparam logic [XO_W-1:0]   XO_CLR     = 10'd264;
   localparam logic [XO_W-1:0]   XO_FLIP    = 10'd40;
   localparam logic [XO_W-1:0]   XO_SET     = 10'd136;

   typedef enum logic [2:0] {
      FOP_NONE = 3'd0,
      FOP_COPY = 3'd1,
      FOP_CLR  = 3'd2,
      FOP_FLIP = 3'd3,
      FOP_SET  = 3'd4
   } fop_e;

   // X-form layout, big-endian bit numbering: prim is word[31:26]
   typedef struct packed {
      logic [PRIM_W-1:0] prim;
      logic [IDX_W-1:0]  dst;
      logic [IDX_W-1:0]  srca;
      logic [IDX_W-1:0]  srcb;
      logic [XO_W-1:0]   xo;
      logic              rec;
   } xword_t;

endpackage

// File: rtl/fpmv_decode.sv
module fpmv_decode
   import fpmv_pkg::*;
#(
   parameter bit SIGN_VARIANTS = 1'b1
) (
   input  logic               valid_i,
   input  logic [INSN_W-1:0]  word_i,
   output fop_e               op_o,
   output logic [IDX_W-1:0]   dst_o,
   output logic [IDX_W-1:0]   src_o,
   output logic               rec_o,
   output logic               exec_o,
   output logic               illegal_o
);

   xword_t xw;
   fop_e   op_raw;

   assign xw = xword_t'(word_i);

   generate
      if (SIGN_VARIANTS) begin : g_full
         always_comb begin
            op_raw = FOP_NONE;
            if (xw.prim == PRIM_FLOAT) begin
               unique case (xw.xo)
                  XO_COPY: op_raw = FOP_COPY;
                  XO_CLR:  op_raw = FOP_CLR;
                  XO_FLIP: op_raw = FOP_FLIP;
                  XO_SET:  op_raw = FOP_SET;
                  default: op_raw = FOP_NONE;
               endcase
            end
         end
      end else begin : g_copy_only
         always_comb begin
            op_raw = FOP_NONE;
            if (xw.prim == PRIM_FLOAT && xw.xo == XO_COPY) op_raw = FOP_COPY;
         end
      end
   endgenerate

   assign op_o      = op_raw;
   assign dst_o     = xw.dst;
   assign src_o     = xw.srcb;
   assign rec_o     = xw.rec;
   assign exec_o    = valid_i && (op_raw != FOP_NONE);
   assign illegal_o = valid_i && (op_raw == FOP_NONE);

endmodule

// File: rtl/fpmv_signop.sv
module fpmv_signop
   import fpmv_pkg::*;
#(
   parameter int unsigned DW = 64
) (
   input  fop_e          op_i,
   input  logic [DW-1:0] src_i,
   output logic [DW-1:0] res_o
);

   localparam int unsigned MAG_W = DW - 1;

   logic           sgn;
   logic [MAG_W-1:0] mag;

   assign sgn = src_i[DW-1];
   assign mag = src_i[MAG_W-1:0];

   always_comb begin
      unique case (op_i)
         FOP_CLR:  res_o = {1'b0, mag};
         FOP_FLIP: res_o = {~sgn, mag};
         FOP_SET:  res_o = {1'b1, mag};
         default:  res_o = src_i;
      endcase
   end

endmodule

// File: rtl/fpmv_regfile.sv
module fpmv_regfile #(
   parameter int unsigned NREGS = 32,
   parameter int unsigned DW    = 64,
   parameter int unsigned AW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o,
   input  logic          tp_we_i,
   input  logic [AW-1:0] tp_addr_i,
   input  logic [DW-1:0] tp_wdata_i,
   output logic [DW-1:0] tp_rdata_o
);

   logic [DW-1:0] mem [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < NREGS; i++) begin
            if (we_i && waddr_i == AW'(i))
               mem[i] <= wdata_i;
            else if (tp_we_i && tp_addr_i == AW'(i))
               mem[i] <= tp_wdata_i;
         end
      end
   end

   assign rdata_o    = mem[raddr_i];
   assign tp_rdata_o = mem[tp_addr_i];

endmodule

// File: rtl/fpmv_crunit.sv
module fpmv_crunit #(
   parameter int unsigned CR_W     = 32,
   parameter int unsigned SR_W     = 32,
   parameter int unsigned FIELD    = 1,
   parameter int unsigned FIELD_W  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_i,
   input  logic [SR_W-1:0] sr_i,
   output logic [CR_W-1:0] cr_o
);

   localparam int unsigned HI = CR_W - 1 - FIELD * FIELD_W;

   logic [CR_W-1:0] cr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cr_q <= '0;
      else if (upd_i)
         cr_q[HI -: FIELD_W] <= sr_i[SR_W-1 -: FIELD_W];
   end

   assign cr_o = cr_q;

endmodule

// File: rtl/fpmv_unit.sv
module fpmv_unit
   import fpmv_pkg::*;
#(
   parameter int unsigned NREGS         = 32,
   parameter int unsigned DATA_W        = 64,
   parameter int unsigned CR_W          = 32,
   parameter int unsigned SR_W          = 32,
   parameter bit          SIGN_VARIANTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [31:0]       insn_word,
   input  logic [SR_W-1:0]   fpscr_in,
   input  logic              tp_we,
   input  logic [4:0]        tp_addr,
   input  logic [DATA_W-1:0] tp_wdata,
   output logic [DATA_W-1:0] tp_rdata,
   output logic              fpr_we,
   output logic [4:0]        fpr_waddr,
   output logic [DATA_W-1:0] fpr_wdata,
   output logic              cr_we,
   output logic [CR_W-1:0]   cr_q,
   output logic              illegal
);

   localparam int unsigned CR_FIELD = 1;
   localparam int unsigned CR_FW    = 4;

   generate
      if (NREGS != (1 << IDX_W)) begin : g_bad_nregs
         $error("fpmv_unit: NREGS must match the 5-bit register fields");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("fpmv_unit: DATA_W must be at least 2");
      end
      if (CR_W < (CR_FIELD + 1) * CR_FW) begin : g_bad_cr
         $error("fpmv_unit: CR_W too small for field 1");
      end
      if (SR_W < CR_FW) begin : g_bad_sr
         $error("fpmv_unit: SR_W too small");
      end
   endgenerate

   fop_e              op;
   logic [IDX_W-1:0]  dst_idx;
   logic [IDX_W-1:0]  src_idx;
   logic              rec;
   logic              exec;
   logic [DATA_W-1:0] rb_data;
   logic [DATA_W-1:0] result;

   fpmv_decode #(.SIGN_VARIANTS(SIGN_VARIANTS)) u_dec (
      .valid_i   (insn_valid),
      .word_i    (insn_word),
      .op_o      (op),
      .dst_o     (dst_idx),
      .src_o     (src_idx),
      .rec_o     (rec),
      .exec_o    (exec),
      .illegal_o (illegal)
   );

   fpmv_regfile #(.NREGS(NREGS), .DW(DATA_W), .AW(IDX_W)) u_rf (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (exec),
      .waddr_i    (dst_idx),
      .wdata_i    (result),
      .raddr_i    (src_idx),
      .rdata_o    (rb_data),
      .tp_we_i    (tp_we),
      .tp_addr_i  (tp_addr),
      .tp_wdata_i (tp_wdata),
      .tp_rdata_o (tp_rdata)
   );

   fpmv_signop #(.DW(DATA_W)) u_sign (
      .op_i  (op),
      .src_i (rb_data),
      .res_o (result)
   );

   fpmv_crunit #(.CR_W(CR_W), .SR_W(SR_W), .FIELD(CR_FIELD), .FIELD_W(CR_FW)) u_cr (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_i (cr_we),
      .sr_i  (fpscr_in),
      .cr_o  (cr_q)
   );

   assign cr_we     = exec && rec;
   assign fpr_we    = exec;
   assign fpr_waddr = dst_idx;
   assign fpr_wdata = result;

endmodule

// File: rtl/fpmv_unit_chk.sv
module fpmv_unit_chk #(
   parameter int unsigned DW   = 64,
   parameter int unsigned CR_W = 32,
   parameter int unsigned SR_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            insn_valid,
   input logic [31:0]     insn_word,
   input logic [SR_W-1:0] fpscr_in,
   input logic            fpr_we,
   input logic [DW-1:0]   fpr_wdata,
   input logic [DW-1:0]   src_data,
   input logic            cr_we,
   input logic [CR_W-1:0] cr_q,
   input logic            illegal
);

   localparam int unsigned HI = CR_W - 5;
   localparam logic [CR_W-1:0] FMASK = {{4{1'b0}}, {4{1'b1}}, {(CR_W-8){1'b0}}};

   // R8
   we_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fpr_we || cr_we || illegal) |-> insn_valid);

   // R9
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!fpr_we && !cr_we));

   // R9
   illegal_cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> $stable(cr_q));

   // R7
   cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cr_we |=> $stable(cr_q));

   // R6
   cr_field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |=> cr_q[HI -: 4] == $past(fpscr_in[SR_W-1 -: 4]));

   // R6
   cr_other_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |=> (cr_q & ~FMASK) == ($past(cr_q) & ~FMASK));

   // R2
   magnitude_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fpr_we |-> fpr_wdata[DW-2:0] == src_data[DW-2:0]);

   // R1
   primary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fpr_we |-> insn_word[31:26] == 6'd63);

endmodule

bind fpmv_unit fpmv_unit_chk #(.DW(DATA_W), .CR_W(CR_W), .SR_W(SR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .insn_word  (insn_word),
   .fpscr_in   (fpscr_in),
   .fpr_we     (fpr_we),
   .fpr_wdata  (fpr_wdata),
   .src_data   (rb_data),
   .cr_we      (cr_we),
   .cr_q       (cr_q),
   .illegal    (illegal)
);

// File: tb/fpmv_unit_tb.sv
module fpmv_unit_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn_word = '0;
   logic [31:0] fpscr_in = '0;
   logic        tp_we = 1'b0;
   logic [4:0]  tp_addr = '0;
   logic [63:0] tp_wdata = '0;
   logic [63:0] tp_rdata;
   logic        fpr_we;
   logic [4:0]  fpr_waddr;
   logic [63:0] fpr_wdata;
   logic        cr_we;
   logic [31:0] cr_q;
   logic        illegal;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [63:0] mdl [32];
   logic [31:0] mcr;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpmv_unit u_dut (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
      .fpscr_in(fpscr_in), .tp_we(tp_we), .tp_addr(tp_addr), .tp_wdata(tp_wdata),
      .tp_rdata(tp_rdata), .fpr_we(fpr_we), .fpr_waddr(fpr_waddr),
      .fpr_wdata(fpr_wdata), .cr_we(cr_we), .cr_q(cr_q), .illegal(illegal)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] pat(input int i);
      case (i)
         0: return 64'h0000_0000_0000_0000;
         1: return 64'h8000_0000_0000_0000;
         2: return 64'h7FF0_0000_0000_0000;
         3: return 64'hFFF0_0000_0000_0000;
         4: return 64'h7FF0_0000_0000_0001;
         5: return 64'h7FF8_0000_0000_0000;
         6: return 64'hFFF4_DEAD_BEEF_0123;
         default: return 64'h3FF0_0000_0000_0000;
      endcase
   endfunction

   function automatic logic [31:0] mkword(input int prim, input int d, input int a,
                                          input int b, input int xo, input int rc);
      return {6'(prim), 5'(d), 5'(a), 5'(b), 10'(xo), 1'(rc)};
   endfunction

   task automatic tp_load(input int a, input logic [63:0] d);
      @(negedge clk);
      tp_we = 1'b1; tp_addr = 5'(a); tp_wdata = d;
      @(negedge clk);
      tp_we = 1'b0;
      mdl[a] = d;
      #1 chk("R12 tp load", tp_rdata, d);
   endtask

   // Drive one word; compute expectations from the requirements.
   task automatic issue(input logic [31:0] w, input logic v, input logic [31:0] sr);
      int prim, xo, d, b, rc, kind;
      logic [63:0] src, exp;
      string rq;
      prim = int'(w[31:26]); d = int'(w[25:21]); b = int'(w[15:11]);
      xo = int'(w[10:1]); rc = int'(w[0]);
      kind = 0;
      if (prim == 63) begin
         if (xo == 72) kind = 1;
         else if (xo == 264) kind = 2;
         else if (xo == 40) kind = 3;
         else if (xo == 136) kind = 4;
      end
      src = mdl[b];
      case (kind)
         2: begin exp = {1'b0, src[62:0]}; rq = "R3"; end
         3: begin exp = {~src[63], src[62:0]}; rq = "R4"; end
         4: begin exp = {1'b1, src[62:0]}; rq = "R5"; end
         default: begin exp = src; rq = "R2"; end
      endcase
      @(negedge clk);
      insn_word = w; insn_valid = v; fpscr_in = sr;
      #1;
      if (!v) begin
         chk("R8 fpr_we", 64'(fpr_we), 64'd0);
         chk("R8 cr_we", 64'(cr_we), 64'd0);
         chk("R8 illegal", 64'(illegal), 64'd0);
      end else if (kind == 0) begin
         chk("R9 illegal", 64'(illegal), 64'd1);
         chk("R9 fpr_we", 64'(fpr_we), 64'd0);
      end else begin
         chk("R1 fpr_we", 64'(fpr_we), 64'd1);
         chk("R1 waddr", 64'(fpr_waddr), 64'(d));
         chk("R9 legal not flagged", 64'(illegal), 64'd0);
         chk({rq, " wdata"}, fpr_wdata, exp);
         chk(rc ? "R6 cr_we" : "R7 cr_we", 64'(cr_we), 64'(rc));
         mdl[d] = exp;
         if (rc != 0) mcr[27:24] = sr[31:28];
      end
      @(negedge clk);
      insn_valid = 1'b0;
      tp_addr = 5'(d);
      #1;
      if (v && kind != 0 && d == b) chk("R10 self move", tp_rdata, exp);
      else chk({(v && kind != 0) ? rq : (v ? "R9" : "R8"), " stored"}, tp_rdata, mdl[d]);
      chk(rc ? "R6 cr" : "R7 cr", 64'(cr_q), 64'(mcr));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int xos [4];
      xos[0] = 72; xos[1] = 264; xos[2] = 40; xos[3] = 136;
      mcr = '0;
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      for (int i = 0; i < 32; i++) begin
         tp_addr = 5'(i);
         #1 chk("R11 reg zero", tp_rdata, 64'd0);
      end
      chk("R11 cr zero", 64'(cr_q), 64'd0);
      chk("R11 idle", 64'({fpr_we, cr_we, illegal}), 64'd0);

      for (int i = 0; i < 8; i++) tp_load(i, pat(i));
      for (int i = 8; i < 32; i++) tp_load(i, {32'(i * 32'h0101_0101), 32'hA5A5_5A5A});

      // all four ops over every special pattern, both record settings
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < 8; s++)
            for (int rc = 0; rc < 2; rc++)
               issue(mkword(63, 8 + ((s * 8 + k * 2 + rc) % 24), 31 - s, s, xos[k], rc), 1'b1,
                     {4'(s * 3 + k + rc * 5), 28'h0ABC_DEF});

      // R1: FRA field has no effect
      for (int a = 0; a < 32; a++)
         issue(mkword(63, 20, a, 6, 72, 0), 1'b1, 32'hFFFF_FFFF);

      // R1: base word 0xFC000090 copies f0 to f0
      issue(32'hFC00_0090, 1'b1, 32'h5000_0000);

      // R8: valid low
      for (int k = 0; k < 4; k++)
         issue(mkword(63, 9, 0, 4, xos[k], 1), 1'b0, 32'hF000_0000);

      // R10: destination equals source
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < 8; s++)
            issue(mkword(63, s, 0, s, xos[k], k % 2), 1'b1, {4'(15 - s), 28'h0});

      // R9: every extended opcode under primary 63
      for (int x = 0; x < 1024; x++)
         issue(mkword(63, 12, 3, 2 + (x % 6), x, 1), 1'b1, {4'(x), 28'h1234567});

      // R9: every primary opcode with the move's extended opcode
      for (int p = 0; p < 64; p++)
         issue(mkword(p, 13, 0, 7, 72, 1), 1'b1, {4'(p), 28'h0});

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule